// File: doc/BRIEF.md
# Row-Rotating Random-Access Scan Array

This block holds a grid of scan storage cells arranged as `ROWS` rows by `COLS` columns. The cell contents feed the logic under test in parallel. Outside test mode the grid acts as an ordinary bank of D flip-flops that take in functional data on every clock.

In test mode a single row is active at any time. The active row is chosen by a one-hot ring register. A strobe returns the ring to row 0, and a second strobe steps it to the next row. There is no address decoder, so a tester walks the rows in a fixed sequence.

Each column has its own scan input and scan output, so a complete row is written or read in one cycle. A forwarding mode makes each column take its stimulus from the column to its left, which turns the active row into a serial shift path. A mask for each column blocks that column's scan-out bit. A capture strobe loads every cell at once from the functional data.

Top module: `sras_array`

## Requirements
- R1: While `rst_ni` is low, every cell reads 0 and row 0 is the active row.
- R2: In test mode, `row_rst_i` makes row 0 active at the next clock. It takes priority over `row_adv_i`.
- R3: In test mode, `row_adv_i` without `row_rst_i` moves the active row from r to r+1 at the next clock. Row `ROWS-1` wraps to row 0.
- R4: In test mode, with `wr_en_i` high, `cap_i` low and `fwd_mode_i` = 0, cell (active row, c) takes `col_si_i[c]` at the next clock. No other row changes.
- R5: In test mode, with `wr_en_i` high, `cap_i` low and `fwd_mode_i` = 1, column 0 of the active row takes `col_si_i[0]`. Each column c>0 takes the previous content of column c-1 of the same row.
- R6: `col_so_o[c]` equals `col_obs_en_i[c]` AND the current content of cell (active row, c). In a write cycle it therefore shows the value from before the write.
- R7: In test mode, `cap_i` loads every cell from `cap_data_i` at the next clock. Cell (r,c) is bit r*COLS+c. Capture takes priority over a write in the same cycle.
- R8: With `test_mode_i` low, every cell loads its `cap_data_i` bit on each clock. The row strobes and `wr_en_i` have no effect, and the active row is kept.
- R9: Exactly one row is active at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | 1 = scan access, 0 = functional flip-flop behaviour |
| row_rst_i | input | 1 | Return the ring to row 0 |
| row_adv_i | input | 1 | Step the ring to the next row |
| wr_en_i | input | 1 | Write the active row from the column inputs |
| fwd_mode_i | input | 1 | 1 = each column takes data from its left neighbour |
| col_si_i | input | COLS | Scan input of each column |
| col_obs_en_i | input | COLS | Scan-out enable of each column |
| cap_i | input | 1 | Parallel capture strobe in test mode |
| cap_data_i | input | ROWS*COLS | Functional data, cell (r,c) at bit r*COLS+c |
| col_so_o | output | COLS | Gated scan output of the active row |
| cells_o | output | ROWS*COLS | All cell contents, cell (r,c) at bit r*COLS+c |

## Verification
Directed patterns come first:
- A full ring walk with one distinct value per row separates a correct wrap from a stuck or skipped row.
- Asserting the row-reset and advance strobes together shows which of the two wins.
- A forwarding write over a known row exposes a wrong shift direction, or an input taken from the wrong column.
- A capture in the same cycle as a write, and a functional-mode cycle with the strobes active, confirm the priorities and the hold of the ring.

Random mixes of writes, captures, rotations, masks and mode changes are then checked each cycle against a reference grid. These catch writes that leak into other rows and scan-out that shows post-write data.

// File: rtl/sras_pkg.sv
package sras_pkg;
  typedef struct packed {
    logic test;
    logic cap;
    logic wr;
  } cell_ctl_t;
endpackage

// File: rtl/sras_row_ring.sv
module sras_row_ring #(
  parameter int ROWS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            test_i,
  input  logic            row_rst_i,
  input  logic            row_adv_i,
  output logic [ROWS-1:0] en_o
);
  localparam logic [ROWS-1:0] FIRST = ROWS'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                en_o <= FIRST;
    else if (test_i) begin
      if (row_rst_i)            en_o <= FIRST;
      else if (row_adv_i)       en_o <= {en_o[ROWS-2:0], en_o[ROWS-1]};
    end
  end

  p_one_row_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en_o) == 1);
  p_row_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i && row_rst_i |=> en_o[0]);
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i && !row_rst_i && row_adv_i && en_o[ROWS-1] |=> en_o[0]);
  p_ring_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |=> $stable(en_o));
endmodule

// File: rtl/sras_col_route.sv
module sras_col_route #(
  parameter int ROWS = 8,
  parameter int COLS = 4
) (
  input  logic [ROWS-1:0]      en_i,
  input  logic [ROWS*COLS-1:0] cells_i,
  input  logic [COLS-1:0]      si_i,
  input  logic [COLS-1:0]      obs_en_i,
  input  logic                 fwd_i,
  output logic [COLS-1:0]      wr_row_o,
  output logic [COLS-1:0]      so_o
);
  logic [COLS-1:0] rd_row;

  always_comb begin
    rd_row = '0;
    for (int r = 0; r < ROWS; r++)
      if (en_i[r]) rd_row = rd_row | cells_i[r*COLS +: COLS];
  end

  assign wr_row_o[0] = si_i[0];
  assign so_o        = rd_row & obs_en_i;

  for (genvar c = 1; c < COLS; c++) begin : g_fwd
    assign wr_row_o[c] = fwd_i ? rd_row[c-1] : si_i[c];
  end
endmodule

// File: rtl/sras_cell_row.sv
module sras_cell_row
  import sras_pkg::*;
#(
  parameter int COLS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cell_ctl_t       ctl_i,
  input  logic            sel_i,
  input  logic [COLS-1:0] cap_row_i,
  input  logic [COLS-1:0] wr_row_i,
  output logic [COLS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     q_o <= '0;
    else if (!ctl_i.test || ctl_i.cap) q_o <= cap_row_i;
    else if (ctl_i.wr && sel_i)      q_o <= wr_row_i;
  end

  p_unsel_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.test && !ctl_i.cap && !(ctl_i.wr && sel_i) |=> $stable(q_o));
  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.test && ctl_i.cap |=> q_o == $past(cap_row_i));
  p_func_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.test |=> q_o == $past(cap_row_i));
endmodule

// File: rtl/sras_array.sv
module sras_array
  import sras_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 test_mode_i,
  input  logic                 row_rst_i,
  input  logic                 row_adv_i,
  input  logic                 wr_en_i,
  input  logic                 fwd_mode_i,
  input  logic [COLS-1:0]      col_si_i,
  input  logic [COLS-1:0]      col_obs_en_i,
  input  logic                 cap_i,
  input  logic [ROWS*COLS-1:0] cap_data_i,
  output logic [COLS-1:0]      col_so_o,
  output logic [ROWS*COLS-1:0] cells_o
);
  logic [ROWS-1:0] row_en;
  logic [COLS-1:0] wr_row;
  cell_ctl_t       ctl;

  assign ctl = '{test: test_mode_i, cap: cap_i, wr: wr_en_i};

  sras_row_ring #(.ROWS(ROWS)) u_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_i(test_mode_i),
    .row_rst_i(row_rst_i), .row_adv_i(row_adv_i), .en_o(row_en)
  );

  sras_col_route #(.ROWS(ROWS), .COLS(COLS)) u_route (
    .en_i(row_en), .cells_i(cells_o), .si_i(col_si_i),
    .obs_en_i(col_obs_en_i), .fwd_i(fwd_mode_i),
    .wr_row_o(wr_row), .so_o(col_so_o)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    sras_cell_row #(.COLS(COLS)) u_row (
      .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl), .sel_i(row_en[r]),
      .cap_row_i(cap_data_i[r*COLS +: COLS]), .wr_row_i(wr_row),
      .q_o(cells_o[r*COLS +: COLS])
    );
  end

  p_so_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_so_o & ~col_obs_en_i) == '0);
endmodule

// File: tb/sras_array_test.sv
module sras_array_test;
  localparam int ROWS = 8;
  localparam int COLS = 4;
  localparam int N    = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tm = 1'b0, rr = 1'b0, ra = 1'b0, we = 1'b0, fw = 1'b0, cp = 1'b0;
  logic [COLS-1:0] si = '0, obs = '0;
  logic [N-1:0]    cd = '0;
  logic [COLS-1:0] so;
  logic [N-1:0]    cells;

  int checks = 0, errors = 0;
  logic [COLS-1:0] mdl [ROWS];
  int mrow = 0;

  always #2 clk = ~clk;

  sras_array #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .test_mode_i(tm), .row_rst_i(rr),
    .row_adv_i(ra), .wr_en_i(we), .fwd_mode_i(fw), .col_si_i(si),
    .col_obs_en_i(obs), .cap_i(cp), .cap_data_i(cd),
    .col_so_o(so), .cells_o(cells)
  );

  function automatic logic [N-1:0] flat_mdl();
    logic [N-1:0] v;
    for (int r = 0; r < ROWS; r++) v[r*COLS +: COLS] = mdl[r];
    return v;
  endfunction

  function automatic logic [COLS-1:0] exp_so();
    return mdl[mrow] & obs;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [COLS-1:0] old;
    old = mdl[mrow];
    if (!tm) begin
      for (int r = 0; r < ROWS; r++) mdl[r] = cd[r*COLS +: COLS];
    end else begin
      if (cp) begin
        for (int r = 0; r < ROWS; r++) mdl[r] = cd[r*COLS +: COLS];
      end else if (we) begin
        for (int c = 0; c < COLS; c++)
          mdl[mrow][c] = (fw && c > 0) ? old[c-1] : si[c];
      end
      if (rr)      mrow = 0;
      else if (ra) mrow = (mrow + 1) % ROWS;
    end
  endtask

  // inputs already driven at a negedge; check scan-out, clock, check cells
  task automatic step(input string req);
    #1;
    chk("R6", N'(so), N'(exp_so()));
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk(req, cells, flat_mdl());
  endtask

  task automatic drive(input logic t, input logic r_, input logic a, input logic w,
                       input logic f, input logic c_, input logic [COLS-1:0] s,
                       input logic [COLS-1:0] o, input logic [N-1:0] d);
    tm = t; rr = r_; ra = a; we = w; fw = f; cp = c_; si = s; obs = o; cd = d;
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int r = 0; r < ROWS; r++) mdl[r] = '0;
    obs = '1;
    #5;
    chk("R1", cells, '0);
    chk("R1", N'(so), '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4/R3: write a distinct value per row while walking the ring, then wrap
    for (int r = 0; r < ROWS; r++) begin
      drive(1, 0, 1, 1, 0, 0, COLS'(r + 3), '1, '0);
      step("R4");
    end
    drive(1, 0, 0, 0, 0, 0, '0, '1, '0);
    step("R3");
    chk("R3", N'(so), N'(COLS'(3)));

    // R2: reset beats advance
    drive(1, 0, 1, 0, 0, 0, '0, '1, '0); step("R3");
    drive(1, 1, 1, 0, 0, 0, '0, '1, '0); step("R2");
    drive(1, 0, 0, 0, 0, 0, '0, '1, '0); #1;
    chk("R2", N'(so), N'(COLS'(3)));
    @(negedge clk);

    // R5: forwarding write on row 0 (value 4'b0011)
    drive(1, 0, 0, 1, 1, 0, 4'b0000, '1, '0); step("R5");
    drive(1, 0, 0, 0, 0, 0, '0, '1, '0); #1;
    chk("R5", N'(so), N'(4'b0110));
    @(negedge clk);

    // R6: mask and pre-write read
    drive(1, 0, 0, 1, 0, 0, 4'b1001, 4'b0101, '0); step("R6");

    // R7: capture beats write
    drive(1, 0, 0, 1, 0, 1, 4'b1111, '1, N'(32'hA5C3_96E1)); step("R7");

    // R8: functional mode ignores strobes, ring kept
    drive(1, 0, 1, 0, 0, 0, '0, '1, '0); step("R3");
    drive(0, 1, 1, 1, 0, 0, '1, '1, N'(32'h1234_5678)); step("R8");
    drive(0, 0, 1, 1, 1, 0, '1, '1, N'(32'h8765_4321)); step("R8");
    drive(1, 0, 0, 0, 0, 0, '0, '1, '0); #1;
    chk("R8", N'(so), N'(mdl[1] & obs));
    chk("R8", N'(mrow), N'(1));
    @(negedge clk);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] k;
      k = $urandom;
      drive(k[3:0] != 0, k[8:4] == 0, k[10:9] == 0, k[12:11] != 0, k[13],
            k[18:14] == 0, COLS'($urandom), COLS'($urandom), N'($urandom));
      step("R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule